// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bus writes into asynchronous serial frames on a single output line. A one-word holding buffer takes a character from the bus side. As soon as the transmit shift register is free, the character moves into it and is shifted out one bit per tick of an external baud tick. Each frame is a low start bit, the data least significant bit first, an optional ninth bit, and a high stop bit. Because the buffer and the shift register are separate, software can queue the next character while the current one is still on the line. A queued character leaves with no idle gap after the current stop bit.

The block reports two status conditions. The buffer-empty flag is the interrupt source and doubles as the ready signal of the write port. The shift-register-empty bit is status only and must be polled. In 9-bit mode the ninth bit comes from a separate ninth-bit register that is written before the low byte. A set ninth bit marks the byte as an address for receivers that use address detection. The shift-clock divider, the receiver, synchronous operation and interrupt gating are outside the block.

The write port is valid/ready. A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low (buffer occupied or block disabled), the source must hold its word. Any `wr_valid` in those cycles is dropped without effect.

Top module: `dbuf_serial_tx`

## Requirements
- R1: While `port_en` or `tx_en` is low, `txd` is high, `shift_empty` is 1 and `buf_empty_irq` is 0. After reset both enables behave as low until they are driven high.
- R2: `buf_empty_irq` is 1 exactly when both enables are high and the holding buffer is empty. Raising the enables with an empty buffer sets it in the same cycle, with no clock edge needed.
- R3: `wr_ready` equals `buf_empty_irq`. An accepted write clears `buf_empty_irq` from the next cycle on. A `wr_valid` while `wr_ready` is 0 is ignored, and the ignored word never appears on `txd`.
- R4: When the shift register is idle, an accepted word moves into it one clock after the write. In that cycle `buf_empty_irq` returns to 1 and `shift_empty` goes to 0, while `txd` stays high until the next `tick`.
- R5: In 8-bit mode (`nine_mode`=0) a frame is 10 bits, each lasting from one `tick` to the next. The bits are 0 (start), data bit 0 through data bit 7, then 1 (stop). The ninth-bit register has no effect on the line in this mode.
- R6: In 9-bit mode a frame is 11 bits, with the ninth bit placed after data bit 7 and before the stop bit. The ninth bit is the value the ninth-bit register held when the low byte was accepted. Later writes to that register do not change an already buffered word.
- R7: `shift_empty` stays 0 from the transfer until the tick that ends the stop bit. It returns to 1 at that tick only if no word is waiting in the holding buffer.
- R8: A word waiting in the holding buffer has its start bit on `txd` from the very tick that ends the previous stop bit. `shift_empty` does not rise between the two frames.
- R9: Dropping `tx_en` or `port_en` aborts any frame in progress and empties the holding buffer. After re-enabling, no old data is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmitter enable |
| nine_mode | input | 1 | 1 = 9-bit characters, 0 = 8-bit characters |
| tick | input | 1 | One-cycle shift-clock pulse from the baud divider |
| ninth_wr | input | 1 | Write strobe for the ninth-bit register |
| ninth_val | input | 1 | Value written to the ninth-bit register |
| wr_valid | input | 1 | Holding-buffer write request |
| wr_ready | output | 1 | Holding buffer can take a word |
| wr_data | input | DATA_W | Low data bits of the character |
| txd | output | 1 | Serial output line, idles high |
| buf_empty_irq | output | 1 | Holding-buffer-empty interrupt flag |
| shift_empty | output | 1 | Shift-register-empty status (polled) |

## Verification
The enable-driven outputs (`buf_empty_irq`, `wr_ready`, and the forced-idle `txd` and `shift_empty`) change in the same cycle as their inputs. The bench samples them a short delay after driving the enables. An accepted write clears the flag one edge later. The idle-case transfer follows on the edge after that, so the bench samples at the falling edge after each of those two edges. Line bits change only on the edge that consumes a `tick`, so every bit, the back-to-back hand-over and the return to empty are read at the falling edge straight after each tick pulse.

// File: rtl/dbuf_serial_tx_pkg.sv
package dbuf_serial_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              ninth_wr,
  input  logic              ninth_val,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              wr_ready,
  output logic              full,
  output logic [DATA_W:0]   word
);
  logic ninth_q;
  logic accept;

  assign wr_ready = active && !full;
  assign accept   = wr_valid && wr_ready;

  // ninth-bit register keeps its value across enables
  always_ff @(posedge clk) begin
    if (!rst_n)        ninth_q <= 1'b0;
    else if (ninth_wr) ninth_q <= ninth_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      full <= 1'b0;
      word <= '0;
    end else if (accept) begin
      full <= 1'b1;
      word <= {ninth_q, wr_data};
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_frame_shift.sv
module tx_frame_shift
  import dbuf_serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            tick,
  input  logic            nine_mode,
  input  logic            ld_valid,
  input  logic [DATA_W:0] ld_word,
  output logic            ld_take,
  output logic            line,
  output logic            idle
);
  localparam int FW = DATA_W + 3;
  localparam int RW = $clog2(FW + 1);

  tx_state_e         state;
  logic [FW-1:0]     sh;
  logic [RW-1:0]     rem;
  logic [FW-1:0]     frame;
  logic [RW-1:0]     nb;
  logic              last;

  always_comb begin
    frame              = '1;
    frame[0]           = 1'b0;
    frame[DATA_W:1]    = ld_word[DATA_W-1:0];
    if (nine_mode) frame[DATA_W+1] = ld_word[DATA_W];
    nb = nine_mode ? RW'(DATA_W + 3) : RW'(DATA_W + 2);
  end

  assign last    = (state == ST_SEND) && tick && (rem == RW'(1));
  assign ld_take = active && ld_valid && ((state == ST_IDLE) || last);
  assign line    = (state == ST_SEND) ? sh[0] : 1'b1;
  assign idle    = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      state <= ST_IDLE;
      sh    <= '1;
      rem   <= '0;
    end else if (ld_take) begin
      sh    <= frame;
      rem   <= nb;
      state <= (state == ST_IDLE) ? ST_ARMED : ST_SEND;
    end else begin
      case (state)
        ST_ARMED: if (tick) state <= ST_SEND;
        ST_SEND: if (tick) begin
          if (last) state <= ST_IDLE;
          else begin
            sh  <= {1'b1, sh[FW-1:1]};
            rem <= rem - RW'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              nine_mode,
  input  logic              tick,
  input  logic              ninth_wr,
  input  logic              ninth_val,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_empty_irq,
  output logic              shift_empty
);
  logic            active;
  logic            full;
  logic            take;
  logic            line;
  logic            idle;
  logic [DATA_W:0] word;

  assign active = port_en && tx_en;

  tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .ninth_wr  (ninth_wr),
    .ninth_val (ninth_val),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .take      (take),
    .wr_ready  (wr_ready),
    .full      (full),
    .word      (word)
  );

  tx_frame_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .tick      (tick),
    .nine_mode (nine_mode),
    .ld_valid  (full),
    .ld_word   (word),
    .ld_take   (take),
    .line      (line),
    .idle      (idle)
  );

  assign buf_empty_irq = active && !full;
  assign shift_empty   = !active || idle;
  assign txd           = !active || line;
endmodule

// File: rtl/dbuf_serial_tx_chk.sv
module dbuf_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic tx_en,
  input logic tick,
  input logic wr_valid,
  input logic wr_ready,
  input logic txd,
  input logic buf_empty_irq,
  input logic shift_empty
);
  a_r1_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && tx_en) |-> (txd && shift_empty && !buf_empty_irq));

  a_r3_accept_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !buf_empty_irq);

  a_r4_idle_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && tx_en && shift_empty && !buf_empty_irq)
      |=> (!shift_empty || !(port_en && tx_en)));

  a_r5_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && tx_en && $past(port_en && tx_en) && !$past(tick)) |-> $stable(txd));

  a_r8_no_gap_when_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && tx_en && $past(port_en && tx_en) && $rose(shift_empty)) |-> buf_empty_irq);
endmodule

bind dbuf_serial_tx dbuf_serial_tx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .port_en       (port_en),
  .tx_en         (tx_en),
  .tick          (tick),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .txd           (txd),
  .buf_empty_irq (buf_empty_irq),
  .shift_empty   (shift_empty)
);

// File: tb/dbuf_serial_tx_bench.sv
module dbuf_serial_tx_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          port_en = 1'b0, tx_en = 1'b0, nine_mode = 1'b0, tick = 1'b0;
  logic          ninth_wr = 1'b0, ninth_val = 1'b0, wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, txd, buf_empty_irq, shift_empty;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  dbuf_serial_tx #(.DATA_W(DW)) u_dbuf_serial_tx (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en),
    .nine_mode(nine_mode), .tick(tick), .ninth_wr(ninth_wr),
    .ninth_val(ninth_val), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .txd(txd), .buf_empty_irq(buf_empty_irq),
    .shift_empty(shift_empty)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] frame_bits(logic [DW-1:0] d, logic nine, logic b9);
    logic [15:0] b = 16'hFFFF;
    b[0]    = 1'b0;
    b[DW:1] = d;
    if (nine) b[DW+1] = b9;
    return b;
  endfunction

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic load_ninth(logic v);
    @(negedge clk) begin ninth_wr = 1'b1; ninth_val = v; end
    @(negedge clk) ninth_wr = 1'b0;
  endtask

  task automatic put_word(logic [DW-1:0] d);
    @(negedge clk) begin wr_valid = 1'b1; wr_data = d; end
    @(negedge clk) wr_valid = 1'b0;
  endtask

  task automatic expect_bits(logic [15:0] b, int n, string req);
    for (int i = 0; i < n; i++) begin
      pulse_tick();
      chk(req, txd, b[i]);
      chk("R7 busy", shift_empty, 0);
    end
  endtask

  task automatic send_frame(logic [DW-1:0] d, logic nine, logic b9);
    string req = nine ? "R6 frame" : "R5 frame";
    @(negedge clk) nine_mode = nine;
    load_ninth(b9);
    put_word(d);
    chk("R3 flag cleared", buf_empty_irq, 0);
    @(negedge clk);
    chk("R4 flag back", buf_empty_irq, 1);
    chk("R4 shift busy", shift_empty, 0);
    chk("R4 line high", txd, 1);
    expect_bits(frame_bits(d, nine, b9), nine ? DW + 3 : DW + 2, req);
    pulse_tick();
    chk("R7 empty after stop", shift_empty, 1);
    chk("R7 line idle", txd, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset txd", txd, 1);
    chk("R1 reset shift_empty", shift_empty, 1);
    chk("R1 reset irq", buf_empty_irq, 0);
    chk("R3 reset ready", wr_ready, 0);
    port_en = 1'b1; #1;
    chk("R2 port only", buf_empty_irq, 0);
    tx_en = 1'b1; #1;
    chk("R2 immediate flag", buf_empty_irq, 1);
    chk("R3 ready follows flag", wr_ready, 1);

    for (int v = 0; v < 256; v++) send_frame(DW'(v), 1'b0, v[3] ^ v[0]);
    for (int v = 0; v < 256; v++)
      for (int b = 0; b < 2; b++) send_frame(DW'(v), 1'b1, b[0]);

    // R8 back-to-back, R6 capture, R3 ignored write
    @(negedge clk) nine_mode = 1'b1;
    load_ninth(1'b1);
    put_word(8'hA5);
    @(negedge clk);
    load_ninth(1'b0);
    put_word(8'h3C);
    load_ninth(1'b1);
    chk("R3 full not ready", wr_ready, 0);
    put_word(8'hFF);
    expect_bits(frame_bits(8'hA5, 1'b1, 1'b1), DW + 3, "R8 first");
    expect_bits(frame_bits(8'h3C, 1'b1, 1'b0), DW + 3, "R8 second R6 R3");
    pulse_tick();
    chk("R7 empty after pair", shift_empty, 1);
    chk("R3 ignored word absent", txd, 1);

    // R9 abort mid-frame
    put_word(8'h00);
    @(negedge clk);
    pulse_tick(); pulse_tick(); pulse_tick();
    chk("R9 mid-frame low", txd, 0);
    tx_en = 1'b0; #1;
    chk("R9 txd high", txd, 1);
    chk("R9 shift empty", shift_empty, 1);
    chk("R9 irq low", buf_empty_irq, 0);
    @(negedge clk) tx_en = 1'b1; #1;
    chk("R9 irq after re-enable", buf_empty_irq, 1);
    for (int i = 0; i < 4; i++) begin
      pulse_tick();
      chk("R9 nothing resent", txd, 1);
      chk("R9 stays empty", shift_empty, 1);
    end
    @(negedge clk) port_en = 1'b0; #1;
    chk("R1 port off irq", buf_empty_irq, 0);
    @(negedge clk) port_en = 1'b1;
    send_frame(8'h81, 1'b0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule